// File: doc/BRIEF.md
# Power Mode Sequencer with PLL Lock Wait

This block sequences a chip between three power modes: full-speed operation, a core-halted idle state and a reduced-frequency state that runs from a divided reference clock with the PLL powered down. It drives clock-enable outputs for the CPU core, for six always-present infrastructure blocks and for a software-gated set of peripherals. It also drives a PLL power request and a select line that picks either the PLL clock or the slow divided clock for the core. The analog PLL and the glitch-free clock multiplexers sit outside the block and are controlled through these enables and selects.

Software moves between modes with a one-cycle request strobe that carries a mode code. Idle ends on a wake event from the RTC alarm, from a general interrupt line, or from any of the external interrupt lines. The external lines count only while the GPIO peripheral clock is enabled. Leaving the slow mode powers the PLL up and starts a down-counter loaded from a programmable lock count. The core stays on the slow clock until that count expires, and the block reports busy for the whole wait.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in full-speed mode (mode_o = 0), with pll_on_o = 1, sel_pll_o = 1, busy_o = 0 and all six infrastructure enables at 1.
- R2: Outside idle, core_clk_en_o = 1 and basic_clk_en_o = 6'h3F. In every mode periph_clk_en_o equals periph_mask_i.
- R3: A request with code 1 made in full-speed mode puts the block in idle (mode_o = 1) on the next cycle. In idle, core_clk_en_o = 0, basic_clk_en_o bits 0..3 (power management, bus, memory controller, interrupt controller) are 1, and bits 4..5 (DMA, external master) are 0.
- R4: In idle, an asserted rtc_alarm_i or other_irq_i returns the block to full-speed mode on the next cycle. So does any bit of ext_irq_i when periph_mask_i bit 0 (the GPIO clock) is 1.
- R5: In idle, ext_irq_i has no effect while periph_mask_i bit 0 is 0.
- R6: A request with code 2 made in full-speed mode puts the block in slow mode (mode_o = 2) on the next cycle, with pll_on_o = 0 and sel_pll_o = 0.
- R7: A request with code 0 made in slow mode sets pll_on_o = 1 and busy_o = 1 on the next cycle and loads the 16-bit lock_cnt_i value L. busy_o then stays high for L+1 cycles with mode_o = 2. On the cycle after that, mode_o = 0, sel_pll_o = 1 and busy_o = 0.
- R8: While busy_o = 1, sel_pll_o stays 0 and every request is ignored.
- R9: A lock count of 0 holds busy_o for exactly one cycle before the switch to the PLL clock.
- R10: The following requests are ignored: code 3, code 1 made in slow mode, any request made in idle, and a request for the mode already active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 2 | Requested mode: 0 full-speed, 1 idle, 2 slow |
| periph_mask_i | input | 8 | Peripheral clock enable mask; bit 0 is the GPIO clock |
| ext_irq_i | input | 24 | External interrupt lines |
| rtc_alarm_i | input | 1 | RTC alarm interrupt |
| other_irq_i | input | 1 | Any other interrupt source |
| lock_cnt_i | input | 16 | PLL lock wait length in cycles |
| core_clk_en_o | output | 1 | CPU core clock enable |
| basic_clk_en_o | output | 6 | Infrastructure enables: pm, bus, mem, intc, dma, ext master |
| periph_clk_en_o | output | 8 | Gated peripheral clock enables |
| pll_on_o | output | 1 | PLL power request |
| sel_pll_o | output | 1 | 1 selects the PLL clock, 0 the slow clock |
| mode_o | output | 2 | Current mode |
| busy_o | output | 1 | Lock wait in progress |

## Verification
The bench checks the exact length of the lock wait for a long count, a short count and a zero count. A design that is off by one in the counter would switch sel_pll_o one cycle early or late. A design that treats zero as "no wait" would skip the busy cycle altogether. Requests sent during the wait, during idle and from the wrong mode are each checked. A design that honoured them would leave the PLL clock selected too early or would enter idle from slow mode. External interrupts are pulsed with the GPIO clock both off and on, so a design that drops the GPIO gate would wake when it should not.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_IDLE   = 2'd1,
    MODE_SLOW   = 2'd2
  } pwr_mode_e;

  localparam int unsigned NBASIC = 6;
  // pm, bus, mem, intc keep running in idle; dma and ext master stop
  localparam logic [NBASIC-1:0] BASIC_IDLE_KEEP = 6'b00_1111;
endpackage

// File: rtl/pwr_lock_timer.sv
module pwr_lock_timer #(
  parameter int unsigned LOCK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LOCK_W-1:0] load_i,
  output logic              busy_o,
  output logic              done_o
);
  logic [LOCK_W-1:0] cnt_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= load_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  AST_LOCK_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1)); // R7
  AST_LOCK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == '0) |=> !busy_q); // R9
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int unsigned NEXT = 24
) (
  input  logic [NEXT-1:0] ext_irq_i,
  input  logic            gpio_clk_en_i,
  input  logic            rtc_alarm_i,
  input  logic            other_irq_i,
  output logic            wake_o
);
  logic ext_hit;
  // external lines are only observable with the GPIO clock running
  assign ext_hit = gpio_clk_en_i && (|ext_irq_i);
  assign wake_o  = ext_hit || rtc_alarm_i || other_irq_i;
endmodule

// File: rtl/pwr_clk_map.sv
module pwr_clk_map
  import pwr_pkg::*;
#(
  parameter int unsigned NPERIPH = 8
) (
  input  pwr_mode_e           mode_i,
  input  logic [NPERIPH-1:0]  periph_mask_i,
  output logic                core_clk_en_o,
  output logic [NBASIC-1:0]   basic_clk_en_o,
  output logic [NPERIPH-1:0]  periph_clk_en_o
);
  logic idle;
  assign idle = (mode_i == MODE_IDLE);

  assign core_clk_en_o = !idle;

  for (genvar g = 0; g < NBASIC; g++) begin : g_basic
    if (BASIC_IDLE_KEEP[g]) begin : g_keep
      assign basic_clk_en_o[g] = 1'b1;
    end else begin : g_stop
      assign basic_clk_en_o[g] = !idle;
    end
  end

  assign periph_clk_en_o = periph_mask_i;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_mode_i,
  input  logic       wake_i,
  input  logic       busy_i,
  input  logic       lock_done_i,
  output pwr_mode_e  mode_o,
  output logic       pll_on_o,
  output logic       sel_pll_o,
  output logic       lock_start_o
);
  pwr_mode_e mode_q;
  logic      pll_q, sel_q;
  logic      req_norm, req_idle, req_slow;

  assign req_norm = req_valid_i && !busy_i && (req_mode_i == 2'd0);
  assign req_idle = req_valid_i && !busy_i && (req_mode_i == 2'd1);
  assign req_slow = req_valid_i && !busy_i && (req_mode_i == 2'd2);

  assign lock_start_o = (mode_q == MODE_SLOW) && req_norm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL;
      pll_q  <= 1'b1;
      sel_q  <= 1'b1;
    end else if (lock_done_i) begin
      mode_q <= MODE_NORMAL;
      sel_q  <= 1'b1;
    end else begin
      unique case (mode_q)
        MODE_NORMAL: begin
          if (req_idle) begin
            mode_q <= MODE_IDLE;
          end else if (req_slow) begin
            mode_q <= MODE_SLOW;
            pll_q  <= 1'b0;
            sel_q  <= 1'b0;
          end
        end
        MODE_IDLE: if (wake_i) mode_q <= MODE_NORMAL;
        MODE_SLOW: if (lock_start_o) pll_q <= 1'b1;
        default:   mode_q <= MODE_NORMAL;
      endcase
    end
  end

  assign mode_o    = mode_q;
  assign pll_on_o  = pll_q;
  assign sel_pll_o = sel_q;

  AST_SLOW_SEL_DURING_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sel_q); // R8
  AST_BUSY_NO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (mode_q != MODE_IDLE)); // R8
  AST_PLL_OFF_IN_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLOW && !busy_i) |-> !pll_q); // R6
  AST_IDLE_NOT_FROM_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLOW) |=> (mode_q != MODE_IDLE)); // R10
  AST_WAKE_EXITS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_IDLE && wake_i) |=> (mode_q == MODE_NORMAL)); // R4
  AST_PLL_SEL_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_q) |-> $past(busy_i)); // R7
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_pkg::*;
#(
  parameter int unsigned NPERIPH  = 8,
  parameter int unsigned NEXT     = 24,
  parameter int unsigned LOCK_W   = 16,
  parameter int unsigned GPIO_IDX = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_mode_i,
  input  logic [NPERIPH-1:0] periph_mask_i,
  input  logic [NEXT-1:0]    ext_irq_i,
  input  logic               rtc_alarm_i,
  input  logic               other_irq_i,
  input  logic [LOCK_W-1:0]  lock_cnt_i,
  output logic               core_clk_en_o,
  output logic [NBASIC-1:0]  basic_clk_en_o,
  output logic [NPERIPH-1:0] periph_clk_en_o,
  output logic               pll_on_o,
  output logic               sel_pll_o,
  output logic [1:0]         mode_o,
  output logic               busy_o
);
  pwr_mode_e mode;
  logic      wake, busy, lock_done, lock_start;

  pwr_wake_detect #(.NEXT(NEXT)) u_wake (
    .ext_irq_i     (ext_irq_i),
    .gpio_clk_en_i (periph_mask_i[GPIO_IDX]),
    .rtc_alarm_i   (rtc_alarm_i),
    .other_irq_i   (other_irq_i),
    .wake_o        (wake)
  );

  pwr_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (lock_start),
    .load_i  (lock_cnt_i),
    .busy_o  (busy),
    .done_o  (lock_done)
  );

  pwr_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_mode_i   (req_mode_i),
    .wake_i       (wake),
    .busy_i       (busy),
    .lock_done_i  (lock_done),
    .mode_o       (mode),
    .pll_on_o     (pll_on_o),
    .sel_pll_o    (sel_pll_o),
    .lock_start_o (lock_start)
  );

  pwr_clk_map #(.NPERIPH(NPERIPH)) u_map (
    .mode_i          (mode),
    .periph_mask_i   (periph_mask_i),
    .core_clk_en_o   (core_clk_en_o),
    .basic_clk_en_o  (basic_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o)
  );

  assign mode_o = mode;
  assign busy_o = busy;

  AST_CORE_STOPPED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |-> (!core_clk_en_o && basic_clk_en_o[3:0] == 4'hF)); // R3
  AST_BUSY_PLL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pll_on_o && mode_o == 2'd2)); // R7
endmodule

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_v = 1'b0;
  logic [1:0]  req_m = 2'd0;
  logic [7:0]  mask = 8'hFF;
  logic [23:0] ext = '0;
  logic        rtc = 1'b0;
  logic        oth = 1'b0;
  logic [15:0] lock = 16'd0;
  logic        core_en, pll_on, sel_pll, busy;
  logic [5:0]  basic_en;
  logic [7:0]  periph_en;
  logic [1:0]  mode;

  pwr_mode_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_mode_i(req_m),
    .periph_mask_i(mask), .ext_irq_i(ext), .rtc_alarm_i(rtc), .other_irq_i(oth),
    .lock_cnt_i(lock), .core_clk_en_o(core_en), .basic_clk_en_o(basic_en),
    .periph_clk_en_o(periph_en), .pll_on_o(pll_on), .sel_pll_o(sel_pll),
    .mode_o(mode), .busy_o(busy)
  );

  always #4 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    run = 0;
  string tag = "R1";

  // behavioural reference model
  int m_mode, m_cnt;
  bit m_busy, m_pll, m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_busy = 0; m_pll = 1; m_sel = 1; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == 0) begin m_busy = 0; m_sel = 1; m_mode = 0; end
      else m_cnt = m_cnt - 1;
    end else if (m_mode == 0) begin
      if (req_v && req_m == 2'd1) m_mode = 1;
      else if (req_v && req_m == 2'd2) begin m_mode = 2; m_pll = 0; m_sel = 0; end
    end else if (m_mode == 1) begin
      if (rtc || oth || (ext != 0 && mask[0])) m_mode = 0;
    end else begin
      if (req_v && req_m == 2'd0) begin m_busy = 1; m_pll = 1; m_cnt = int'(lock); end
    end
  end

  task automatic chk(string fld, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, fld, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    #2;
    if (run) begin
      chk("mode", int'(mode), m_mode);
      chk("busy", int'(busy), int'(m_busy));
      chk("pll_on", int'(pll_on), int'(m_pll));
      chk("sel_pll", int'(sel_pll), int'(m_sel));
      chk("core_en", int'(core_en), (m_mode == 1) ? 0 : 1);
      chk("basic_en", int'(basic_en), (m_mode == 1) ? 'h0F : 'h3F);
      chk("periph_en", int'(periph_en), int'(mask));
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles >= 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      summary();
    end
  end

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(logic [1:0] code);
    @(negedge clk); req_v = 1'b1; req_m = code;
    @(negedge clk); req_v = 1'b0; req_m = 2'd0;
  endtask

  task automatic pulse_wake(bit e, bit r, bit o);
    @(negedge clk); ext = e ? 24'h80_0010 : '0; rtc = r; oth = o;
    @(negedge clk); ext = '0; rtc = 1'b0; oth = 1'b0;
  endtask

  initial begin
    idle_cycles(3);
    run = 1;                      // R1: outputs compared during and after reset
    idle_cycles(2);
    rst_n = 1'b1;
    idle_cycles(3);

    tag = "R2";
    mask = 8'hA5; idle_cycles(2);
    mask = 8'h5A; idle_cycles(2);
    mask = 8'hFF; idle_cycles(2);

    tag = "R3";
    request(2'd1); idle_cycles(3);
    tag = "R10";                  // requests in idle are ignored
    request(2'd2); request(2'd0); idle_cycles(2);

    tag = "R5";
    mask = 8'hFE; idle_cycles(1);
    pulse_wake(1, 0, 0); idle_cycles(3);

    tag = "R4";
    mask = 8'h01; idle_cycles(1);
    pulse_wake(1, 0, 0); idle_cycles(2);
    request(2'd1); idle_cycles(2);
    pulse_wake(0, 1, 0); idle_cycles(2);
    request(2'd1); idle_cycles(2);
    mask = 8'h00;
    pulse_wake(0, 0, 1); idle_cycles(2);
    mask = 8'hC3;

    tag = "R6";
    request(2'd2); idle_cycles(3);
    tag = "R10";
    request(2'd1); request(2'd3); request(2'd2); idle_cycles(2);

    tag = "R7";
    lock = 16'd5;
    request(2'd0);
    lock = 16'd9;                 // later change must not affect running wait
    tag = "R8";
    request(2'd2); request(2'd1);
    idle_cycles(8);

    tag = "R9";
    request(2'd2); idle_cycles(2);
    lock = 16'd0;
    request(2'd0); idle_cycles(4);

    tag = "R7";
    request(2'd2); idle_cycles(2);
    lock = 16'd40;
    request(2'd0); idle_cycles(10);
    tag = "R8";
    request(2'd0); request(2'd1); idle_cycles(40);

    tag = "R10";
    request(2'd0); request(2'd3); idle_cycles(3);

    tag = "R1";
    @(negedge clk); rst_n = 1'b0;
    idle_cycles(2);
    rst_n = 1'b1;
    idle_cycles(3);
    summary();
  end
endmodule